// File: doc/BRIEF.md
# EDID Fetch Sequencer over I2C-over-AUX

This block reads a display's EDID through an AUX channel engine using I2C-over-AUX transactions. After a `start` pulse it walks the 128-byte base block in 16-byte pieces. For each piece it first sends a one-byte I2C write that holds the byte offset, with the middle-of-transaction flag set. It then sends a 16-byte I2C read. Each byte that is read comes out on a simple stream, tagged with its EDID index, so the consumer can write it into its own buffer.

If the base block's extension flag (byte 126) is nonzero, the block goes on to read a second 128-byte block at offsets 128 to 240. A single-cycle `done` then reports success and the total size. Failed attempts are retried at three levels. A single piece can be retried. A defer reply makes the next attempt send only the read. When a piece runs out of tries, the whole EDID read starts again from offset 0. When the whole read runs out of tries, the block reports failure.

The AUX engine is outside this block. It takes one request per `reqStart` pulse. It answers with `rspDone` and a reply code, and on an acknowledged read it also returns the 16 data bytes on `rspBuf`.

Top module: `edid_fetch`

## Requirements
- R1: Every transaction attempt begins with a one-cycle `bufClear` pulse, and a request (`reqStart`) follows in the very next cycle.
- R2: The offset phase is a request with `reqWrite`=1, `reqMot`=1 and `reqLen`=1. Its `reqByte` equals the piece offset (piece number times 16). Its `reqAddr` is the 7-bit device address (default 0x50) with all upper address bits zero.
- R3: The read phase is sent only after the offset write is acknowledged, or right after a defer (see R5). It has `reqWrite`=0, `reqMot`=0 and `reqLen`=16, and uses the same `reqAddr`.
- R4: Reply codes on `rspCode` are 0 = ACK, 1 = NACK, 2 = AUX defer, 3 = I2C defer. A NACK in either phase fails the attempt. So does a missing reply, meaning no `rspDone` within REPLY_TIMEOUT cycles of the request. A defer on the offset write also fails the attempt. The next attempt then starts again with the offset write.
- R5: After a read phase answered with code 2 or code 3, the next attempt sends only the read request, without the offset write.
- R6: Each piece gets at most PIECE_RETRIES attempts. When they are used up, the whole EDID read restarts with the offset write for offset 0.
- R7: The whole read is tried at most READ_RETRIES times. After the last failure, `done` pulses with `ok`=0 and `size`=0.
- R8: After each acknowledged read, the 16 bytes come out on 16 consecutive cycles with `edidValid`=1. Byte k is `rspBuf[8k+7:8k]`, and `edidIdx` is the piece offset plus k.
- R9: If byte 126 of the base block is zero, `done` pulses after the eighth piece with `ok`=1 and `size`=128, and no offset of 128 or more is requested.
- R10: If byte 126 is nonzero, the pieces at offsets 128 to 240 are fetched as well, and `done` reports `ok`=1 and `size`=256.
- R11: `done` is a one-cycle pulse. `ok` and `size` keep their values until the next accepted `start`. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an EDID fetch (ignored while busy) |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Fetch succeeded (valid from done on) |
| size | output | 9 | Total bytes fetched: 128, 256, or 0 on failure |
| bufClear | output | 1 | Clear the engine's data buffer and leave address-only mode off |
| reqStart | output | 1 | Issue one AUX transaction |
| reqWrite | output | 1 | 1 = I2C write, 0 = I2C read |
| reqMot | output | 1 | Middle-of-transaction flag |
| reqLen | output | 5 | Transaction byte count |
| reqAddr | output | 20 | AUX address; the I2C device address sits in the low bits |
| reqByte | output | 8 | Data byte 0 for the offset write |
| rspDone | input | 1 | Engine reply strobe |
| rspCode | input | 2 | Reply kind: 0 ACK, 1 NACK, 2 AUX defer, 3 I2C defer |
| rspBuf | input | 128 | Read data, byte k in bits 8k+7:8k |
| edidValid | output | 1 | Stream byte valid |
| edidByte | output | 8 | Stream byte |
| edidIdx | output | 8 | EDID index of the stream byte |

## Verification
The bench builds the block with PIECE_RETRIES=3, READ_RETRIES=2 and REPLY_TIMEOUT=8. This lets piece-level exhaustion, whole-read restarts and total failure occur within a few dozen transactions. The short timeout lets a silent engine cut an attempt short quickly. A behavioural engine model keeps a device read pointer that advances only on acknowledged reads. A read sent without its offset write therefore returns the right bytes only if the defer path really skipped the write. The model follows a scripted list of reply codes, so NACKs, both defer kinds and missing replies can be placed on chosen transactions.

// File: rtl/edid_fetch_pkg.sv
package edid_fetch_pkg;
  localparam int PIECE_BYTES   = 16;
  localparam int BLOCK_PIECES  = 8;
  localparam int MAX_PIECES    = 2 * BLOCK_PIECES;
  localparam int EXT_FLAG_BYTE = 126;

  typedef enum logic [1:0] {
    RSP_ACK       = 2'd0,
    RSP_NACK      = 2'd1,
    RSP_AUX_DEFER = 2'd2,
    RSP_I2C_DEFER = 2'd3
  } rsp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;  // back to piece 0, drop extension flag
    logic advance;  // next piece
    logic capture;  // load reply data and start streaming
  } dp_cmd_t;
endpackage

// File: rtl/edid_fetch_dp.sv
module edid_fetch_dp
  import edid_fetch_pkg::*;
#(
  parameter int IDX_W = $clog2(MAX_PIECES),
  parameter int SEL_W = $clog2(PIECE_BYTES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dp_cmd_t                  cmd,
  input  logic [PIECE_BYTES*8-1:0] rspBuf,
  output logic [IDX_W-1:0]         pieceIdx,
  output logic [IDX_W+SEL_W-1:0]   pieceOffset,
  output logic                     extFlag,
  output logic                     streamLast,
  output logic                     edidValid,
  output logic [7:0]               edidByte,
  output logic [IDX_W+SEL_W-1:0]   edidIdx
);
  localparam int EXT_PIECE = EXT_FLAG_BYTE / PIECE_BYTES;
  localparam int EXT_LANE  = EXT_FLAG_BYTE % PIECE_BYTES;

  logic [PIECE_BYTES*8-1:0] shiftReg;
  logic [SEL_W-1:0]         byteSel;
  logic                     streaming;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pieceIdx  <= '0;
      extFlag   <= 1'b0;
      streaming <= 1'b0;
      byteSel   <= '0;
      shiftReg  <= '0;
    end else begin
      if (cmd.restart) begin
        pieceIdx <= '0;
        extFlag  <= 1'b0;
      end else if (cmd.advance) begin
        pieceIdx <= pieceIdx + 1'b1;
      end
      if (cmd.capture) begin
        shiftReg  <= rspBuf;
        streaming <= 1'b1;
        byteSel   <= '0;
        if (pieceIdx == IDX_W'(EXT_PIECE))
          extFlag <= |rspBuf[EXT_LANE*8 +: 8];
      end else if (streaming) begin
        shiftReg <= shiftReg >> 8;
        byteSel  <= byteSel + 1'b1;
        if (byteSel == SEL_W'(PIECE_BYTES - 1)) streaming <= 1'b0;
      end
    end
  end

  assign pieceOffset = {pieceIdx, SEL_W'(0)};
  assign streamLast  = streaming && (byteSel == SEL_W'(PIECE_BYTES - 1));
  assign edidValid   = streaming;
  assign edidByte    = shiftReg[7:0];
  assign edidIdx     = {pieceIdx, byteSel};
endmodule

// File: rtl/edid_fetch_ctrl.sv
module edid_fetch_ctrl
  import edid_fetch_pkg::*;
#(
  parameter int PIECE_RETRIES = 10,
  parameter int READ_RETRIES  = 3,
  parameter int REPLY_TIMEOUT = 1024,
  parameter int IDX_W         = $clog2(MAX_PIECES),
  parameter int SEL_W         = $clog2(PIECE_BYTES),
  parameter int LEN_W         = $clog2(PIECE_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   rspDone,
  input  logic [1:0]             rspCode,
  input  logic [IDX_W-1:0]       pieceIdx,
  input  logic                   extFlag,
  input  logic                   streamLast,
  output dp_cmd_t                cmd,
  output logic                   busy,
  output logic                   done,
  output logic                   ok,
  output logic [IDX_W+SEL_W:0]   size,
  output logic                   bufClear,
  output logic                   reqStart,
  output logic                   reqWrite,
  output logic                   reqMot,
  output logic [LEN_W-1:0]       reqLen
);
  localparam int PT_W = $clog2(PIECE_RETRIES + 1);
  localparam int WT_W = $clog2(READ_RETRIES + 1);
  localparam int TO_W = $clog2(REPLY_TIMEOUT + 1);
  localparam int LAST_BASE = BLOCK_PIECES - 1;
  localparam int LAST_EXT  = MAX_PIECES - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_CLEAR, S_OFFS_REQ, S_OFFS_WAIT,
    S_READ_REQ, S_READ_WAIT, S_STREAM, S_FINISH
  } state_e;

  state_e          state, stateNxt;
  logic [PT_W-1:0] pieceTry;
  logic [WT_W-1:0] wholeTry;
  logic [TO_W-1:0] waitCnt;
  logic            skipOffset;
  logic            timedOut, attemptFail, deferSeen, wholeRestart, goodEnd, badEnd;
  logic [IDX_W:0]  pieceCount;
  rsp_e            code;

  assign code       = rsp_e'(rspCode);
  assign timedOut   = (waitCnt == TO_W'(REPLY_TIMEOUT - 1));
  assign pieceCount = {1'b0, pieceIdx} + 1'b1;

  always_comb begin
    stateNxt     = state;
    cmd          = '0;
    attemptFail  = 1'b0;
    deferSeen    = 1'b0;
    wholeRestart = 1'b0;
    goodEnd      = 1'b0;
    badEnd       = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        stateNxt    = S_CLEAR;
        cmd.restart = 1'b1;
      end
      S_CLEAR:    stateNxt = skipOffset ? S_READ_REQ : S_OFFS_REQ;
      S_OFFS_REQ: stateNxt = S_OFFS_WAIT;
      S_OFFS_WAIT: begin
        if (rspDone) begin
          if (code == RSP_ACK) stateNxt = S_READ_REQ;
          else                 attemptFail = 1'b1;
        end else if (timedOut) attemptFail = 1'b1;
      end
      S_READ_REQ: stateNxt = S_READ_WAIT;
      S_READ_WAIT: begin
        if (rspDone) begin
          if (code == RSP_ACK) begin
            cmd.capture = 1'b1;
            stateNxt    = S_STREAM;
          end else begin
            attemptFail = 1'b1;
            deferSeen   = (code == RSP_AUX_DEFER) || (code == RSP_I2C_DEFER);
          end
        end else if (timedOut) attemptFail = 1'b1;
      end
      S_STREAM: if (streamLast) begin
        if (pieceIdx == IDX_W'(LAST_EXT) ||
            (pieceIdx == IDX_W'(LAST_BASE) && !extFlag)) begin
          stateNxt = S_FINISH;
          goodEnd  = 1'b1;
        end else begin
          cmd.advance = 1'b1;
          stateNxt    = S_CLEAR;
        end
      end
      S_FINISH: stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
    if (attemptFail) begin
      if (pieceTry == PT_W'(PIECE_RETRIES - 1)) begin
        if (wholeTry == WT_W'(READ_RETRIES - 1)) begin
          stateNxt = S_FINISH;
          badEnd   = 1'b1;
        end else begin
          stateNxt     = S_CLEAR;
          cmd.restart  = 1'b1;
          wholeRestart = 1'b1;
        end
      end else begin
        stateNxt = S_CLEAR;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      pieceTry   <= '0;
      wholeTry   <= '0;
      waitCnt    <= '0;
      skipOffset <= 1'b0;
      ok         <= 1'b0;
      size       <= '0;
    end else begin
      state <= stateNxt;
      if (state == S_OFFS_REQ || state == S_READ_REQ) waitCnt <= '0;
      else if (state == S_OFFS_WAIT || state == S_READ_WAIT) waitCnt <= waitCnt + 1'b1;

      if (cmd.restart)           skipOffset <= 1'b0;
      else if (deferSeen)        skipOffset <= 1'b1;
      else if (state == S_CLEAR) skipOffset <= 1'b0;

      if (cmd.restart || cmd.advance) pieceTry <= '0;
      else if (attemptFail)           pieceTry <= pieceTry + 1'b1;

      if (state == S_IDLE && start) wholeTry <= '0;
      else if (wholeRestart)        wholeTry <= wholeTry + 1'b1;

      if (state == S_IDLE && start) begin
        ok   <= 1'b0;
        size <= '0;
      end else if (goodEnd) begin
        ok   <= 1'b1;
        size <= {pieceCount, SEL_W'(0)};
      end else if (badEnd) begin
        ok   <= 1'b0;
        size <= '0;
      end
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FINISH);
  assign bufClear = (state == S_CLEAR);
  assign reqStart = (state == S_OFFS_REQ) || (state == S_READ_REQ);
  assign reqWrite = (state == S_OFFS_REQ);
  assign reqMot   = (state == S_OFFS_REQ);
  assign reqLen   = (state == S_OFFS_REQ) ? LEN_W'(1) : LEN_W'(PIECE_BYTES);
endmodule

// File: rtl/edid_fetch.sv
module edid_fetch
  import edid_fetch_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR      = 7'h50,
  parameter int         PIECE_RETRIES = 10,
  parameter int         READ_RETRIES  = 3,
  parameter int         REPLY_TIMEOUT = 1024
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic         ok,
  output logic [8:0]   size,
  output logic         bufClear,
  output logic         reqStart,
  output logic         reqWrite,
  output logic         reqMot,
  output logic [4:0]   reqLen,
  output logic [19:0]  reqAddr,
  output logic [7:0]   reqByte,
  input  logic         rspDone,
  input  logic [1:0]   rspCode,
  input  logic [127:0] rspBuf,
  output logic         edidValid,
  output logic [7:0]   edidByte,
  output logic [7:0]   edidIdx
);
  localparam int IDX_W = $clog2(MAX_PIECES);
  localparam int SEL_W = $clog2(PIECE_BYTES);

  dp_cmd_t          cmd;
  logic [IDX_W-1:0] pieceIdx;
  logic             extFlag, streamLast;

  edid_fetch_ctrl #(
    .PIECE_RETRIES(PIECE_RETRIES), .READ_RETRIES(READ_RETRIES),
    .REPLY_TIMEOUT(REPLY_TIMEOUT), .IDX_W(IDX_W), .SEL_W(SEL_W), .LEN_W(5)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rspDone(rspDone), .rspCode(rspCode),
    .pieceIdx(pieceIdx), .extFlag(extFlag), .streamLast(streamLast), .cmd(cmd),
    .busy(busy), .done(done), .ok(ok), .size(size), .bufClear(bufClear),
    .reqStart(reqStart), .reqWrite(reqWrite), .reqMot(reqMot), .reqLen(reqLen)
  );

  edid_fetch_dp #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rspBuf(rspBuf), .pieceIdx(pieceIdx),
    .pieceOffset(reqByte), .extFlag(extFlag), .streamLast(streamLast),
    .edidValid(edidValid), .edidByte(edidByte), .edidIdx(edidIdx)
  );

  // device address in the low field, upper address fields zero
  assign reqAddr = {13'b0, DEV_ADDR};
endmodule

// File: rtl/edid_fetch_chk.sv
module edid_fetch_chk (
  input logic       clk,
  input logic       rstN,
  input logic       done,
  input logic       ok,
  input logic [8:0] size,
  input logic       bufClear,
  input logic       reqStart,
  input logic       reqWrite,
  input logic       reqMot,
  input logic [4:0] reqLen,
  input logic [7:0] reqByte,
  input logic       edidValid,
  input logic [7:0] edidIdx
);
  assert_clear_then_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    bufClear |=> reqStart);
  assert_offs_fields_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqStart && reqWrite) |-> (reqMot && reqLen == 5'd1 && reqByte[3:0] == 4'd0));
  assert_read_fields_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqStart && !reqWrite) |-> (!reqMot && reqLen == 5'd16));
  assert_fail_size_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !ok) |-> (size == 9'd0));
  assert_stream_order_R8: assert property (@(posedge clk) disable iff (!rstN)
    (edidValid && $past(edidValid)) |-> (edidIdx == $past(edidIdx) + 8'd1));
  assert_ok_size_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && ok) |-> (size == 9'd128 || size == 9'd256)); // also R10
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && $stable(ok) && $stable(size)));
  assert_no_stream_at_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !edidValid);
endmodule

bind edid_fetch edid_fetch_chk u_chk (
  .clk(clk), .rstN(rstN), .done(done), .ok(ok), .size(size), .bufClear(bufClear),
  .reqStart(reqStart), .reqWrite(reqWrite), .reqMot(reqMot), .reqLen(reqLen),
  .reqByte(reqByte), .edidValid(edidValid), .edidIdx(edidIdx)
);

// File: tb/edid_fetch_bench.sv
module edid_fetch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PR = 3;
  localparam int RR = 2;
  localparam int TO = 8;
  localparam int NORESP = 4;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic busy, done, ok, bufClear, reqStart, reqWrite, reqMot, edidValid;
  logic [8:0] size;
  logic [4:0] reqLen;
  logic [19:0] reqAddr;
  logic [7:0] reqByte, edidByte, edidIdx;
  logic rspDone = 1'b0;
  logic [1:0] rspCode = 2'd0;
  logic [127:0] rspBuf = '0;

  edid_fetch #(.PIECE_RETRIES(PR), .READ_RETRIES(RR), .REPLY_TIMEOUT(TO)) u_edid_fetch (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .ok(ok),
    .size(size), .bufClear(bufClear), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqMot(reqMot), .reqLen(reqLen), .reqAddr(reqAddr), .reqByte(reqByte),
    .rspDone(rspDone), .rspCode(rspCode), .rspBuf(rspBuf), .edidValid(edidValid),
    .edidByte(edidByte), .edidIdx(edidIdx)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0, nFail = 0, nClear = 0, nDone = 0, addrBad = 0, fmtBad = 0;
  int replyQ[$];
  logic [15:0] expQ[$];
  bit txW[$];
  logic [7:0] txOff[$];
  logic [7:0] extVal = 8'd0;
  logic [7:0] devPtr = 8'd0;
  bit reported = 1'b0;

  function automatic logic [7:0] memByte(input int a);
    if (a == 126) return extVal;
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  // AUX engine model: device pointer moves on ACKed offset writes and reads
  initial begin
    forever begin
      @(negedge clk);
      rspDone = 1'b0;
      if (reqStart) begin
        automatic int code = (replyQ.size() != 0) ? replyQ.pop_front() : 0;
        automatic bit w = reqWrite;
        automatic logic [7:0] off = reqByte;
        txW.push_back(w);
        txOff.push_back(off);
        if (reqAddr != 20'h00050) addrBad++;
        if (w && (reqLen != 5'd1 || !reqMot)) fmtBad++;
        if (!w && (reqLen != 5'd16 || reqMot)) fmtBad++;
        if (code != NORESP) begin
          repeat (2) @(negedge clk);
          if (code == 0) begin
            if (w) devPtr = off;
            else begin
              for (int k = 0; k < 16; k++) rspBuf[k*8 +: 8] = memByte(int'(devPtr) + k);
              devPtr = devPtr + 8'd16;
            end
          end
          rspCode = 2'(code);
          rspDone = 1'b1;
        end
      end
    end
  end

  // scoreboard monitor for the byte stream (R8)
  always @(negedge clk) begin
    if (bufClear) nClear++;
    if (done) nDone++;
    if (edidValid) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R8 unexpected byte: actual idx=%0d byte=%0d expected none", edidIdx, edidByte);
      end else begin
        automatic logic [15:0] e = expQ.pop_front();
        if ({edidIdx, edidByte} != e) begin
          nFail++;
          $display("FAIL R8 stream: actual idx=%0d byte=%0d expected idx=%0d byte=%0d",
                   edidIdx, edidByte, e[15:8], e[7:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  task automatic pushPieces(input int first, input int last);
    for (int p = first; p <= last; p++)
      for (int k = 0; k < 16; k++)
        expQ.push_back({8'(p * 16 + k), memByte(p * 16 + k)});
  endtask

  task automatic prep(input logic [7:0] ext);
    extVal = ext;
    txW.delete();
    txOff.delete();
    nClear = 0;
    nDone = 0;
  endtask

  task automatic runFetch(output bit gotOk, output int gotSize);
    int n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    gotOk = ok;
    gotSize = int'(size);
    @(negedge clk);
    checkEq("R11", "done pulse width", int'(done), 0);
    checkEq("R11", "size held", int'(size), gotSize);
    repeat (4) @(negedge clk);
    checkEq("R8", "expected bytes left", expQ.size(), 0);
  endtask

  initial begin
    bit gOk;
    int gSize;
    repeat (3) @(negedge clk);
    checkEq("R11", "reset done", int'(done), 0);
    checkEq("R11", "reset busy", int'(busy), 0);
    checkEq("R8", "reset edidValid", int'(edidValid), 0);
    checkEq("R1", "reset reqStart/bufClear", int'(reqStart | bufClear), 0);
    rstN = 1'b1;
    @(negedge clk);

    // base block only
    prep(8'h00); pushPieces(0, 7); runFetch(gOk, gSize);
    checkEq("R9", "ok", int'(gOk), 1);
    checkEq("R9", "size", gSize, 128);
    checkEq("R9", "transactions", txW.size(), 16);
    checkEq("R1", "clears", nClear, 8);
    checkEq("R2", "first is write", int'(txW[0]), 1);
    checkEq("R2", "first offset", int'(txOff[0]), 0);
    checkEq("R3", "second is read", int'(txW[1]), 0);
    checkEq("R2", "last offset", int'(txOff[14]), 112);

    // with extension
    prep(8'h01); pushPieces(0, 15); runFetch(gOk, gSize);
    checkEq("R10", "ok", int'(gOk), 1);
    checkEq("R10", "size", gSize, 256);
    checkEq("R10", "transactions", txW.size(), 32);
    checkEq("R10", "offset 240", int'(txOff[30]), 240);

    // NACK on a read
    prep(8'h00); replyQ = '{0, 1}; pushPieces(0, 7); runFetch(gOk, gSize);
    checkEq("R4", "ok after NACK", int'(gOk), 1);
    checkEq("R4", "offset rewritten", int'(txW[2]), 1);
    checkEq("R4", "rewrite offset", int'(txOff[2]), 0);
    checkEq("R4", "transactions", txW.size(), 18);
    checkEq("R1", "clears", nClear, 9);

    // AUX defer then I2C defer
    prep(8'h00); replyQ = '{0, 2, 0, 0, 3}; pushPieces(0, 7); runFetch(gOk, gSize);
    checkEq("R5", "read-only after AUX defer", int'(txW[2]), 0);
    checkEq("R5", "next piece write offset", int'(txOff[3]), 16);
    checkEq("R5", "read-only after I2C defer", int'(txW[5]), 0);
    checkEq("R5", "transactions", txW.size(), 18);
    checkEq("R5", "ok", int'(gOk), 1);

    // missing reply
    prep(8'h00); replyQ = '{NORESP}; pushPieces(0, 7); runFetch(gOk, gSize);
    checkEq("R4", "write after timeout", int'(txW[1]), 1);
    checkEq("R4", "offset after timeout", int'(txOff[1]), 0);
    checkEq("R4", "transactions", txW.size(), 17);

    // piece exhaustion restarts whole read
    prep(8'h00); replyQ = '{0, 0, 1, 1, 1}; pushPieces(0, 0); pushPieces(0, 7);
    runFetch(gOk, gSize);
    checkEq("R6", "restart is write", int'(txW[5]), 1);
    checkEq("R6", "restart offset", int'(txOff[5]), 0);
    checkEq("R6", "transactions", txW.size(), 21);
    checkEq("R6", "ok", int'(gOk), 1);

    // total failure
    prep(8'h00); replyQ = '{1, 1, 1, 1, 1, 1}; runFetch(gOk, gSize);
    checkEq("R7", "ok", int'(gOk), 0);
    checkEq("R7", "size", gSize, 0);
    checkEq("R7", "transactions", txW.size(), 6);

    // start while busy is ignored
    prep(8'h00); pushPieces(0, 7);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    begin
      int n = 0;
      while (busy && n < 20000) begin @(negedge clk); n++; end
    end
    repeat (10) @(negedge clk);
    checkEq("R11", "done count", nDone, 1);
    checkEq("R11", "transactions", txW.size(), 16);
    checkEq("R11", "size held", int'(size), 128);
    checkEq("R8", "expected bytes left", expQ.size(), 0);

    checkEq("R2", "bad address", addrBad, 0);
    checkEq("R3", "bad request fields", fmtBad, 0);
    report();
  end
endmodule